// File: doc/BRIEF.md
# CAN Error Event Collector

This block gathers protocol error events from a CAN bus engine and holds them in a small set of byte-wide registers. The engine drives one-cycle pulses for each kind of event. Status events (bus lock, overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning) set sticky flags directly. Detailed error kinds (ACK delimiter, dominant and recessive bit errors, CRC, ACK, form, stuff) are recorded in an error-code register, and any of them also sets the generic bus-error flag.

Software reads the registers through a simple strobe bus. It clears flags and codes by writing a byte with the chosen bits at 0 and all other bits at 1. A per-flag enable register selects which flags feed a summary error bit in the interrupt status register. An interrupt-enable bit gates that summary onto a registered interrupt line. A display-mode bit in the code register chooses whether codes pile up until cleared or show only the most recent error. The transmit and receive error counters kept by the engine are mirrored here as read-only registers.

Register map (3-bit address): 0 flags, 1 flag enables, 2 error code, 3 interrupt enable, 4 interrupt status, 5 transmit error counter, 6 receive error counter, 7 unmapped.

Top module: `cer_err_collector`

## Requirements
- R1: After reset every register reads 0, so display mode is "latest", and `err_irq` is low.
- R2: A pulse on `flag_evt[i]` sets flag bit i at address 0. The bit order from 7 to 0 is bus lock, overload sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. Any pulse on `code_evt` also sets bit 0. Flags are set whatever their enables hold.
- R3: A bus write to address 0 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R4: When a hardware set and a software clear hit the same flag or code bit in one cycle, the bit ends at 1.
- R5: Code bits 6 to 0 at address 2 are, in order, ACK delimiter, dominant bit error, recessive bit error, CRC, ACK, form and stuff, with `code_evt[i]` mapping to bit i. With display mode (bit 7) at 1, new code events are ORed into the held bits.
- R6: With display mode at 0, a cycle carrying any code event replaces bits 6 to 0 with exactly that cycle's events. Cycles without code events leave the bits alone.
- R7: A bus write to address 2 clears code bits 6 to 0 where the written bit is 0, and loads bit 7 (display mode) from the written value.
- R8: Interrupt status at address 4 reads bit 5 as the OR over all flags ANDed with their enables at address 1. All other bits read 0, and writes to address 4 have no effect.
- R9: Only bit 5 of interrupt enable (address 3) is stored. `err_irq` is a register that, one cycle after any state, equals the status summary of that state ANDed with that enable bit.
- R10: The transmit (address 5) and receive (address 6) counters load from `tec_val` and `rec_val` when `tec_ld` and `rec_ld` pulse. Bus writes to these addresses have no effect.
- R11: A read strobe at a clock edge puts the value the addressed register held before that edge on `bus_rdata` after the edge. Address 7 reads 0, and `bus_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_evt | input | 8 | Status event pulses, one per flag bit |
| code_evt | input | 7 | Detailed error-kind pulses, one per code bit |
| tec_ld | input | 1 | Load strobe for the transmit error counter |
| tec_val | input | 8 | New transmit error counter value |
| rec_ld | input | 1 | Load strobe for the receive error counter |
| rec_val | input | 8 | New receive error counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| err_irq | output | 1 | Registered error interrupt |

## Verification
Two functions can land on the same clock edge: a hardware event setting a flag or code bit, and a software write clearing that same bit. The bench drives random event pulses in the same cycles as random clear writes to the flag and code registers. It also applies a directed case that pulses a flag and writes all-zero to it on one edge. Each outcome is judged by reading the register back and comparing it with a bench model in which a set outweighs a clear, and in which "latest" display mode lets the cycle's events replace the code field outright.

// File: rtl/cer_pkg.sv
package cer_pkg;
  localparam int ADDR_W   = 3;
  localparam int SUM_BIT  = 5;
  localparam int N_CNT    = 2;

  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CODE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ISTAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_TEC   = 3'd5;
  localparam logic [ADDR_W-1:0] A_REC   = 3'd6;
endpackage

// File: rtl/cer_flag_bank.sv
// Sticky flag bank: hardware set has priority over a write-zero clear.
module cer_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else if (set_i[i])
        flag_q[i] <= 1'b1;
      else if (clr_we && !keep_mask[i])
        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cer_code_capture.sv
// Error-code store with accumulate / latest-only display modes.
module cer_code_capture #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         we,
  input  logic [W:0]   wdata,
  output logic [W-1:0] code_q,
  output logic         mode_q
);
  logic [W-1:0] after_wr;
  logic [W-1:0] code_nxt;

  always_comb begin
    after_wr = we ? (code_q & wdata[W-1:0]) : code_q;
    if (|evt)
      code_nxt = mode_q ? (after_wr | evt) : evt;
    else
      code_nxt = after_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= code_nxt;
      if (we)
        mode_q <= wdata[W];
    end
  end
endmodule

// File: rtl/cer_count_regs.sv
// Read-only mirrors of engine-owned error counters.
module cer_count_regs #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ld,
  input  logic [N*W-1:0] val,
  output logic [N*W-1:0] cnt_q
);
  for (genvar k = 0; k < N; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[k*W +: W] <= '0;
      else if (ld[k])
        cnt_q[k*W +: W] <= val[k*W +: W];
    end
  end
endmodule

// File: rtl/cer_err_collector.sv
module cer_err_collector
  import cer_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_W-1:0]    flag_evt,
  input  logic [REG_W-2:0]    code_evt,
  input  logic                tec_ld,
  input  logic [REG_W-1:0]    tec_val,
  input  logic                rec_ld,
  input  logic [REG_W-1:0]    rec_val,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                err_irq
);
  localparam int CODE_W = REG_W - 1;

  logic [REG_W-1:0]       flag_q;
  logic [REG_W-1:0]       fen_q;
  logic [CODE_W-1:0]      code_q;
  logic                   mode_q;
  logic                   ien_q;
  logic [N_CNT*REG_W-1:0] cnt_q;
  logic [REG_W-1:0]       tec_q;
  logic [REG_W-1:0]       rec_q;
  logic [REG_W-1:0]       flag_set;
  logic                   summary;
  logic                   wr_flag, wr_code;
  logic [REG_W-1:0]       rd_mux;

  assign wr_flag  = bus_wr && (bus_addr == A_FLAG);
  assign wr_code  = bus_wr && (bus_addr == A_CODE);
  assign flag_set = flag_evt | {{(REG_W-1){1'b0}}, |code_evt};

  cer_flag_bank #(.W(REG_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (flag_set),
    .clr_we    (wr_flag),
    .keep_mask (bus_wdata),
    .flag_q    (flag_q)
  );

  cer_code_capture #(.W(CODE_W)) u_code (
    .clk    (clk),
    .rst    (rst),
    .evt    (code_evt),
    .we     (wr_code),
    .wdata  (bus_wdata),
    .code_q (code_q),
    .mode_q (mode_q)
  );

  cer_count_regs #(.W(REG_W), .N(N_CNT)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ld    ({rec_ld, tec_ld}),
    .val   ({rec_val, tec_val}),
    .cnt_q (cnt_q)
  );

  assign tec_q = cnt_q[0 +: REG_W];
  assign rec_q = cnt_q[REG_W +: REG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q <= '0;
      ien_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_FEN) fen_q <= bus_wdata;
      if (bus_addr == A_IEN) ien_q <= bus_wdata[SUM_BIT];
    end
  end

  assign summary = |(flag_q & fen_q);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_FLAG:  rd_mux = flag_q;
      A_FEN:   rd_mux = fen_q;
      A_CODE:  rd_mux = {mode_q, code_q};
      A_IEN:   rd_mux[SUM_BIT] = ien_q;
      A_ISTAT: rd_mux[SUM_BIT] = summary;
      A_TEC:   rd_mux = tec_q;
      A_REC:   rd_mux = rec_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      err_irq   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      err_irq <= summary & ien_q;
    end
  end
endmodule

// File: rtl/cer_err_collector_chk.sv
module cer_err_collector_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] flag_evt,
  input logic [REG_W-2:0] code_evt,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] flag_q,
  input logic [REG_W-2:0] code_q,
  input logic             mode_q,
  input logic             ien_q,
  input logic             err_irq,
  input logic             tec_ld,
  input logic [REG_W-1:0] tec_q
);
  // R2: every pulsed flag event is held the next cycle
  a_r2_evt_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (flag_evt != '0) |=> ((flag_q & $past(flag_evt)) == $past(flag_evt)));

  // R3: a flag write with no events keeps exactly the bits written as 1
  a_r3_write_zero_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0 && flag_evt == '0 && code_evt == '0)
    |=> (flag_q == ($past(flag_q) & $past(bus_wdata))));

  // R6: latest mode shows only the newest code events
  a_r6_latest_replaces: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && code_evt != '0) |=> (code_q == $past(code_evt)));

  // R9: interrupt stays low after a cycle with the enable cleared
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (!ien_q) |=> !err_irq);

  // R10: bus writes never touch the transmit counter
  a_r10_counter_read_only: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd5 && !tec_ld) |=> $stable(tec_q));
endmodule

bind cer_err_collector cer_err_collector_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flag_evt  (flag_evt),
  .code_evt  (code_evt),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .flag_q    (flag_q),
  .code_q    (code_q),
  .mode_q    (mode_q),
  .ien_q     (ien_q),
  .err_irq   (err_irq),
  .tec_ld    (tec_ld),
  .tec_q     (tec_q)
);

// File: tb/cer_err_collector_tb.sv
`timescale 1ns/1ps
module cer_err_collector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] flag_evt = '0;
  logic [6:0] code_evt = '0;
  logic       tec_ld = 1'b0, rec_ld = 1'b0;
  logic [7:0] tec_val = '0, rec_val = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       err_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_flag, m_fen, m_code, m_tec, m_rec;
  logic       m_ien;

  always #2.5 clk = ~clk;

  cer_err_collector dut_i (
    .clk(clk), .rst(rst), .flag_evt(flag_evt), .code_evt(code_evt),
    .tec_ld(tec_ld), .tec_val(tec_val), .rec_ld(rec_ld), .rec_val(rec_val),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_irq(err_irq)
  );

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_flag;
      3'd1: return m_fen;
      3'd2: return m_code;
      3'd3: return {2'b00, m_ien, 5'b0};
      3'd4: return {2'b00, |(m_flag & m_fen), 5'b0};
      3'd5: return m_tec;
      3'd6: return m_rec;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2/R3/R4";
      3'd1: return "R8";
      3'd2: return "R5/R6/R7";
      3'd3: return "R9";
      3'd4: return "R8";
      3'd5, 3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, predict from pre-edge model, check after edge.
  task automatic step(input logic [7:0] fe, input logic [6:0] ce,
                      input logic tl, input logic [7:0] tv,
                      input logic rl, input logic [7:0] rv,
                      input logic wr, input logic rd, input logic [2:0] a,
                      input logic [7:0] wd, input string tag);
    logic [7:0] exp_rd;
    logic       exp_irq;
    logic [6:0] base;
    flag_evt = fe; code_evt = ce; tec_ld = tl; tec_val = tv;
    rec_ld = rl; rec_val = rv; bus_wr = wr; bus_rd = rd;
    bus_addr = a; bus_wdata = wd;
    exp_rd  = model_read(a);
    exp_irq = |(m_flag & m_fen) & m_ien;
    @(posedge clk);
    // model update
    m_flag = ((wr && a == 3'd0) ? (m_flag & wd) : m_flag) | fe | {7'b0, |ce};
    if (wr && a == 3'd1) m_fen = wd;
    if (wr && a == 3'd3) m_ien = wd[5];
    base = (wr && a == 3'd2) ? (m_code[6:0] & wd[6:0]) : m_code[6:0];
    if (|ce) base = m_code[7] ? (base | ce) : ce;
    m_code = {((wr && a == 3'd2) ? wd[7] : m_code[7]), base};
    if (tl) m_tec = tv;
    if (rl) m_rec = rv;
    #1;
    check("R9 irq", {7'b0, err_irq}, {7'b0, exp_irq});
    if (rd) check(tag.len() > 0 ? tag : req_of(a), bus_rdata, exp_rd);
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    step(8'h00, 7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(8'h00, 7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, a, d, "");
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h00C0FFEE);
    m_flag = '0; m_fen = '0; m_code = '0; m_tec = '0; m_rec = '0; m_ien = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register and the interrupt
    for (int a = 0; a < 8; a++) rd_reg(3'(a), "R1 reset");

    // R2: each status event sets its own bit, enables all zero
    for (int i = 1; i < 8; i++) begin
      step(8'(1 << i), 7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, "");
      rd_reg(3'd0, "R2 flag set");
    end
    // R3: keep bits 7..4, clear 3..0; all-ones write changes nothing
    wr_reg(3'd0, 8'hF0);
    rd_reg(3'd0, "R3 partial clear");
    wr_reg(3'd0, 8'hFF);
    rd_reg(3'd0, "R3 ones keep");
    // R4: set and clear of bit 2 on the same edge
    step(8'h04, 7'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00, "");
    rd_reg(3'd0, "R4 set beats clear");

    // R6: latest mode, successive code events replace the field; bit 0 flag also set (R2)
    step(8'h00, 7'h48, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, "");
    step(8'h00, 7'h01, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, "");
    rd_reg(3'd2, "R6 latest only");
    rd_reg(3'd0, "R2 bus error flag");
    // R7 + R5: enter accumulate mode, codes pile up
    wr_reg(3'd2, 8'h80);
    rd_reg(3'd2, "R7 mode load");
    step(8'h00, 7'h10, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, "");
    step(8'h00, 7'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, "");
    rd_reg(3'd2, "R5 accumulate");
    // R4 on the code register
    step(8'h00, 7'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 3'd2, 8'h80, "");
    rd_reg(3'd2, "R4 code set beats clear");

    // R8/R9: enable flags and interrupt, status write ignored
    wr_reg(3'd1, 8'h04);
    wr_reg(3'd4, 8'h00);
    rd_reg(3'd4, "R8 summary");
    wr_reg(3'd3, 8'hFF);
    rd_reg(3'd3, "R9 enable stored");
    wr_reg(3'd0, 8'h00);
    rd_reg(3'd4, "R8 summary cleared");

    // R10: counters load from engine, bus writes ignored
    step(8'h00, 7'h00, 1'b1, 8'h7F, 1'b1, 8'h80, 1'b0, 1'b0, 3'd0, 8'h00, "");
    wr_reg(3'd5, 8'h11);
    wr_reg(3'd6, 8'h22);
    rd_reg(3'd5, "R10 tx counter");
    rd_reg(3'd6, "R10 rx counter");
    // R11: unmapped address
    rd_reg(3'd7, "R11 unmapped");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] fe, wd;
      logic [6:0] ce;
      logic [2:0] a;
      logic       wr, rd;
      fe = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      ce = ($urandom % 6 == 0) ? 7'($urandom) : 7'h00;
      a  = 3'($urandom);
      wr = ($urandom % 4 == 0);
      rd = !wr && ($urandom % 2 == 0);
      wd = ($urandom % 2 == 0) ? ~(8'h1 << ($urandom % 8)) : 8'($urandom);
      step(fe, ce, ($urandom % 16 == 0), 8'($urandom),
           ($urandom % 16 == 0), 8'($urandom), wr, rd, a, wd, "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: run hung");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule